// File: doc/BRIEF.md
# PLL Operating Mode Controller

This block supervises one digital PLL channel. After a hard reset it waits in an initialization state until a completion strobe arrives, then moves through four operating modes: free-run, lock acquisition, locked and holdover. It picks which of the qualified reference inputs the loop follows. When that reference drops out, it decides what happens next: move to another usable input, coast on stored history, or fall back to free-run.

During lock acquisition the controller can apply a wider loop bandwidth code, and it returns to the normal code once lock is reached. It also drives an active-low loss-of-lock flag and an enable that keeps the synthesized clocks quiet until initialization is finished. Clock qualification, the phase detector, the loop filter and the oscillator are outside this block. They appear here only as the `in_valid`, `lock_ok` and `hist_valid` inputs. Each channel has its own instance, so soft reset and fastlock enable apply to one channel only.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and afterwards until `init_done` is seen, `mode` is 0 (init), `sel_idx` is 0, `lol_n` is 0 and `clk_out_en` is 0. Mode codes are 0 init, 1 free-run, 2 acquisition, 3 locked and 4 holdover.
- R2: In init, an edge with `init_done` high moves the mode to 1. `clk_out_en` is 1 in every mode other than init.
- R3: In free-run or holdover, if any eligible input exists, the next edge enters acquisition with `sel_idx` set to the lowest-numbered eligible input. With no eligible input the mode stays where it is, and `lock_ok` has no effect.
- R4: With `auto_sel` = 1 every input whose `in_valid` bit is set is eligible. With `auto_sel` = 0 only input `man_sel` is eligible, and only if its `in_valid` bit is set.
- R5: In acquisition, with the selected input still eligible, `lock_ok` high moves the mode to locked at the next edge. Locked is entered only from acquisition.
- R6: The selected input fails when it is no longer eligible while in acquisition or locked. If another input is eligible, the next edge enters acquisition on the lowest-numbered of those inputs, even if `lock_ok` is high.
- R7: The selected input fails and no other input is eligible. The next edge enters holdover if `hist_valid` is high and free-run otherwise. `sel_idx` keeps its value.
- R8: `bw_active` equals `bw_fast` when the mode is acquisition and `fastlock_en` is 1. In every other case it equals `bw_normal`.
- R9: `lol_n` is 1 exactly while the mode is locked.
- R10: `soft_rst` high in any mode other than init gives mode 1 and `sel_idx` 0 at the next edge. This takes priority over all other transitions. In init, `soft_rst` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst | input | 1 | Channel soft reset, returns to free-run |
| init_done | input | 1 | Initialization complete strobe |
| in_valid | input | NUM_IN | Qualified input clock flags |
| auto_sel | input | 1 | 1 = automatic input choice, 0 = manual |
| man_sel | input | SEL_W | Input index used in manual selection |
| lock_ok | input | 1 | Phase lock achieved indication |
| hist_valid | input | 1 | Holdover history is usable |
| fastlock_en | input | 1 | Use fastlock bandwidth while acquiring |
| bw_normal | input | BW_W | Normal loop bandwidth code |
| bw_fast | input | BW_W | Fastlock loop bandwidth code |
| mode | output | 3 | Current operating mode |
| sel_idx | output | SEL_W | Selected input index |
| bw_active | output | BW_W | Bandwidth code applied to the loop |
| lol_n | output | 1 | Loss of lock, active low |
| clk_out_en | output | 1 | Output clocks allowed |

## Verification
The assertions check the following on every cycle: the wait in init, the exit from init, the entry into locked from acquisition, soft-reset priority, the holdover or free-run choice when every input is gone, and the agreement of the bandwidth code, lock flag and output enable with the mode. Some behaviour is shown only by the bench's scenarios: the lowest-index choice among several valid inputs, manual eligibility when the chosen input changes under a locked loop, switching to another input while `lock_ok` is still high, and the retained selection after a fallback.

// File: rtl/pll_mode_pkg.sv
// Shared types for the PLL operating mode controller.
// Assumes the mode register is three bits wide; codes 5..7 are unused.
package pll_mode_pkg;
    typedef enum logic [2:0] {
        MODE_INIT   = 3'd0,
        MODE_FREE   = 3'd1,
        MODE_ACQ    = 3'd2,
        MODE_LOCKED = 3'd3,
        MODE_HOLD   = 3'd4
    } pll_mode_e;
endpackage

// File: rtl/pll_lowest_pick.sv
// Priority encoder: reports whether any request bit is set and the index
// of the lowest-numbered one. Purely combinational.
module pll_lowest_pick #(
    parameter int NUM_IN = 4,
    localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic [NUM_IN-1:0] req,
    output logic              found,
    output logic [SEL_W-1:0]  idx
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/pll_input_picker.sv
// Works out which inputs may be used (automatic or manual selection),
// whether the currently selected input is still usable, and the best
// first choice and alternative choice. Assumes in_valid is already
// qualified and synchronous to clk.
module pll_input_picker #(
    parameter int NUM_IN = 4,
    localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic [NUM_IN-1:0] in_valid,
    input  logic              auto_sel,
    input  logic [SEL_W-1:0]  man_sel,
    input  logic [SEL_W-1:0]  cur_sel,
    output logic              any_elig,
    output logic [SEL_W-1:0]  first_idx,
    output logic              cur_ok,
    output logic              alt_any,
    output logic [SEL_W-1:0]  alt_idx
);
    logic [NUM_IN-1:0] man_hit;
    logic [NUM_IN-1:0] cur_hit;
    logic [NUM_IN-1:0] elig;
    logic [NUM_IN-1:0] alt_req;

    // One-hot decode of the manual index and of the current selection.
    for (genvar g = 0; g < NUM_IN; g++) begin : g_hit
        assign man_hit[g] = (man_sel == SEL_W'(g));
        assign cur_hit[g] = (cur_sel == SEL_W'(g));
    end

    // Eligibility mask depends on the selection policy.
    always_comb begin
        elig = auto_sel ? in_valid : (in_valid & man_hit);
    end

    assign cur_ok  = |(elig & cur_hit);
    assign alt_req = elig & ~cur_hit;

    pll_lowest_pick #(.NUM_IN(NUM_IN)) u_first (
        .req   (elig),
        .found (any_elig),
        .idx   (first_idx)
    );

    pll_lowest_pick #(.NUM_IN(NUM_IN)) u_alt (
        .req   (alt_req),
        .found (alt_any),
        .idx   (alt_idx)
    );
endmodule

// File: rtl/pll_mode_fsm.sv
// Mode state machine and selected-input register. Every transition takes
// one clock. Hard reset is synchronous active-low; soft reset overrides
// every transition except while still in init.
module pll_mode_fsm
    import pll_mode_pkg::*;
#(
    parameter int NUM_IN = 4,
    localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             init_done,
    input  logic             lock_ok,
    input  logic             hist_valid,
    input  logic             any_elig,
    input  logic [SEL_W-1:0] first_idx,
    input  logic             cur_ok,
    input  logic             alt_any,
    input  logic [SEL_W-1:0] alt_idx,
    output pll_mode_e        mode_q,
    output logic [SEL_W-1:0] sel_q
);
    pll_mode_e        mode_d;
    logic [SEL_W-1:0] sel_d;

    // Next-state decision, including the failure chain for a lost input.
    always_comb begin
        mode_d = mode_q;
        sel_d  = sel_q;
        unique case (mode_q)
            MODE_INIT: begin
                if (init_done) mode_d = MODE_FREE;
            end
            MODE_FREE, MODE_HOLD: begin
                if (any_elig) begin
                    mode_d = MODE_ACQ;
                    sel_d  = first_idx;
                end
            end
            MODE_ACQ, MODE_LOCKED: begin
                if (!cur_ok) begin
                    if (alt_any) begin
                        mode_d = MODE_ACQ;
                        sel_d  = alt_idx;
                    end else if (hist_valid) begin
                        mode_d = MODE_HOLD;
                    end else begin
                        mode_d = MODE_FREE;
                    end
                end else if (mode_q == MODE_ACQ && lock_ok) begin
                    mode_d = MODE_LOCKED;
                end
            end
            default: mode_d = MODE_INIT;
        endcase
        if (soft_rst && mode_q != MODE_INIT) begin
            mode_d = MODE_FREE;
            sel_d  = '0;
        end
    end

    // State registers with synchronous hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_INIT;
            sel_q  <= '0;
        end else begin
            mode_q <= mode_d;
            sel_q  <= sel_d;
        end
    end
endmodule

// File: rtl/pll_mode_out.sv
// Output decode from the registered mode: bandwidth code select,
// loss-of-lock flag and output clock enable. Combinational.
module pll_mode_out
    import pll_mode_pkg::*;
#(
    parameter int BW_W = 4
) (
    input  pll_mode_e        mode_q,
    input  logic             fastlock_en,
    input  logic [BW_W-1:0]  bw_normal,
    input  logic [BW_W-1:0]  bw_fast,
    output logic [BW_W-1:0]  bw_active,
    output logic             lol_n,
    output logic             clk_out_en
);
    // Wide bandwidth only while acquiring with fastlock allowed.
    always_comb begin
        bw_active = (mode_q == MODE_ACQ && fastlock_en) ? bw_fast : bw_normal;
    end

    assign lol_n      = (mode_q == MODE_LOCKED);
    assign clk_out_en = (mode_q != MODE_INIT);
endmodule

// File: rtl/pll_mode_ctrl.sv
// Top of one PLL channel's operating mode controller. Ties together the
// input picker, the mode state machine and the output decode. One
// instance per channel; resets and fastlock enable are per instance.
module pll_mode_ctrl
    import pll_mode_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int BW_W   = 4,
    localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              init_done,
    input  logic [NUM_IN-1:0] in_valid,
    input  logic              auto_sel,
    input  logic [SEL_W-1:0]  man_sel,
    input  logic              lock_ok,
    input  logic              hist_valid,
    input  logic              fastlock_en,
    input  logic [BW_W-1:0]   bw_normal,
    input  logic [BW_W-1:0]   bw_fast,
    output logic [2:0]        mode,
    output logic [SEL_W-1:0]  sel_idx,
    output logic [BW_W-1:0]   bw_active,
    output logic              lol_n,
    output logic              clk_out_en
);
    pll_mode_e        mode_q;
    logic [SEL_W-1:0] sel_q;
    logic             any_elig;
    logic [SEL_W-1:0] first_idx;
    logic             cur_ok;
    logic             alt_any;
    logic [SEL_W-1:0] alt_idx;

    pll_input_picker #(.NUM_IN(NUM_IN)) u_pick (
        .in_valid  (in_valid),
        .auto_sel  (auto_sel),
        .man_sel   (man_sel),
        .cur_sel   (sel_q),
        .any_elig  (any_elig),
        .first_idx (first_idx),
        .cur_ok    (cur_ok),
        .alt_any   (alt_any),
        .alt_idx   (alt_idx)
    );

    pll_mode_fsm #(.NUM_IN(NUM_IN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .init_done  (init_done),
        .lock_ok    (lock_ok),
        .hist_valid (hist_valid),
        .any_elig   (any_elig),
        .first_idx  (first_idx),
        .cur_ok     (cur_ok),
        .alt_any    (alt_any),
        .alt_idx    (alt_idx),
        .mode_q     (mode_q),
        .sel_q      (sel_q)
    );

    pll_mode_out #(.BW_W(BW_W)) u_out (
        .mode_q      (mode_q),
        .fastlock_en (fastlock_en),
        .bw_normal   (bw_normal),
        .bw_fast     (bw_fast),
        .bw_active   (bw_active),
        .lol_n       (lol_n),
        .clk_out_en  (clk_out_en)
    );

    assign mode    = mode_q;
    assign sel_idx = sel_q;
endmodule

// File: rtl/pll_mode_ctrl_chk.sv
// Property checker for pll_mode_ctrl, attached through bind. Observes
// ports only; has no outputs.
module pll_mode_ctrl_chk #(
    parameter int NUM_IN = 4,
    parameter int BW_W   = 4,
    localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              init_done,
    input logic [NUM_IN-1:0] in_valid,
    input logic              auto_sel,
    input logic [SEL_W-1:0]  man_sel,
    input logic              lock_ok,
    input logic              hist_valid,
    input logic              fastlock_en,
    input logic [BW_W-1:0]   bw_normal,
    input logic [BW_W-1:0]   bw_fast,
    input logic [2:0]        mode,
    input logic [SEL_W-1:0]  sel_idx,
    input logic [BW_W-1:0]   bw_active,
    input logic              lol_n,
    input logic              clk_out_en
);
    localparam logic [2:0] M_INIT = 3'd0;
    localparam logic [2:0] M_FREE = 3'd1;
    localparam logic [2:0] M_ACQ  = 3'd2;
    localparam logic [2:0] M_LOCK = 3'd3;
    localparam logic [2:0] M_HOLD = 3'd4;

    p_init_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_INIT && !init_done) |=> (mode == M_INIT && sel_idx == '0));

    p_init_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_INIT && init_done) |=> (mode == M_FREE));

    p_out_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_INIT) |-> !clk_out_en);

    p_lock_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_ACQ && lock_ok && !soft_rst && in_valid[sel_idx]
         && (auto_sel || man_sel == sel_idx)) |=> (mode == M_LOCK));

    p_lock_from_acq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_LOCK && $past(mode) != M_LOCK) |-> ($past(mode) == M_ACQ));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_ACQ || mode == M_LOCK) && !soft_rst && in_valid == '0 && hist_valid)
        |=> (mode == M_HOLD && $stable(sel_idx)));

    p_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_ACQ || mode == M_LOCK) && !soft_rst && in_valid == '0 && !hist_valid)
        |=> (mode == M_FREE && $stable(sel_idx)));

    p_bw_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_ACQ && fastlock_en) |-> (bw_active == bw_fast));

    p_bw_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != M_ACQ || !fastlock_en) |-> (bw_active == bw_normal));

    p_lol_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lol_n |-> (mode == M_LOCK));

    p_soft_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && mode != M_INIT) |=> (mode == M_FREE && sel_idx == '0));

    p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode <= M_HOLD);
endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk #(.NUM_IN(NUM_IN), .BW_W(BW_W)) u_chk (.*);

// File: tb/tb_pll_mode_ctrl.sv
// Bench for pll_mode_ctrl: a vector table walked cycle by cycle, then
// directed checks for hard reset, init wait and soft reset in init.
module tb_pll_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, soft_rst, init_done, auto_sel, lock_ok, hist_valid, fastlock_en;
    logic [3:0] in_valid;
    logic [1:0] man_sel;
    logic [3:0] bw_normal, bw_fast;
    logic [2:0] mode;
    logic [1:0] sel_idx;
    logic [3:0] bw_active;
    logic       lol_n, clk_out_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pll_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .init_done(init_done),
        .in_valid(in_valid), .auto_sel(auto_sel), .man_sel(man_sel),
        .lock_ok(lock_ok), .hist_valid(hist_valid), .fastlock_en(fastlock_en),
        .bw_normal(bw_normal), .bw_fast(bw_fast), .mode(mode), .sel_idx(sel_idx),
        .bw_active(bw_active), .lol_n(lol_n), .clk_out_en(clk_out_en)
    );

    // Stimulus {soft,init,valid[4],auto,man[2],lock,hist,fl} | expected {mode[3],sel[2],lol_n,bw[4]}
    localparam int NV = 20;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0,1'b0,4'b0000,1'b1,2'd0,1'b0,1'b0,1'b1, 3'd0,2'd0,1'b0,4'h3}, // R1 wait in init
        {1'b0,1'b1,4'b0000,1'b1,2'd0,1'b0,1'b0,1'b1, 3'd1,2'd0,1'b0,4'h3}, // R2 init done
        {1'b0,1'b0,4'b0000,1'b1,2'd0,1'b1,1'b0,1'b1, 3'd1,2'd0,1'b0,4'h3}, // R3 no input, lock ignored
        {1'b0,1'b0,4'b0110,1'b1,2'd0,1'b0,1'b0,1'b1, 3'd2,2'd1,1'b0,4'hC}, // R3 lowest valid, R8 fast
        {1'b0,1'b0,4'b0110,1'b1,2'd0,1'b0,1'b0,1'b1, 3'd2,2'd1,1'b0,4'hC}, // R5 waits for lock
        {1'b0,1'b0,4'b0110,1'b1,2'd0,1'b1,1'b0,1'b1, 3'd3,2'd1,1'b1,4'h3}, // R5 locked, R9
        {1'b0,1'b0,4'b0110,1'b1,2'd0,1'b1,1'b0,1'b1, 3'd3,2'd1,1'b1,4'h3}, // R9 stays locked
        {1'b0,1'b0,4'b0100,1'b1,2'd0,1'b1,1'b0,1'b1, 3'd2,2'd2,1'b0,4'hC}, // R6 switch despite lock
        {1'b0,1'b0,4'b0100,1'b1,2'd0,1'b1,1'b0,1'b1, 3'd3,2'd2,1'b1,4'h3}, // R5 relock
        {1'b0,1'b0,4'b0000,1'b1,2'd0,1'b0,1'b1,1'b1, 3'd4,2'd2,1'b0,4'h3}, // R7 holdover
        {1'b0,1'b0,4'b0000,1'b1,2'd0,1'b0,1'b1,1'b1, 3'd4,2'd2,1'b0,4'h3}, // R7 holds
        {1'b0,1'b0,4'b1000,1'b1,2'd0,1'b0,1'b1,1'b1, 3'd2,2'd3,1'b0,4'hC}, // R3 leave holdover
        {1'b0,1'b0,4'b1000,1'b1,2'd0,1'b1,1'b1,1'b0, 3'd3,2'd3,1'b1,4'h3}, // R5 lock, fastlock off
        {1'b0,1'b0,4'b0000,1'b1,2'd0,1'b0,1'b0,1'b0, 3'd1,2'd3,1'b0,4'h3}, // R7 free-run, sel kept
        {1'b0,1'b0,4'b1011,1'b0,2'd2,1'b0,1'b0,1'b0, 3'd1,2'd3,1'b0,4'h3}, // R4 manual input absent
        {1'b0,1'b0,4'b0100,1'b0,2'd2,1'b0,1'b0,1'b0, 3'd2,2'd2,1'b0,4'h3}, // R4 manual, R8 normal bw
        {1'b0,1'b0,4'b0101,1'b0,2'd2,1'b1,1'b0,1'b0, 3'd3,2'd2,1'b1,4'h3}, // R5 manual lock
        {1'b0,1'b0,4'b0101,1'b0,2'd0,1'b1,1'b0,1'b0, 3'd2,2'd0,1'b0,4'h3}, // R6 manual index moved
        {1'b1,1'b0,4'b0101,1'b0,2'd0,1'b1,1'b0,1'b0, 3'd1,2'd0,1'b0,4'h3}, // R10 soft reset
        {1'b0,1'b0,4'b0101,1'b0,2'd0,1'b0,1'b0,1'b1, 3'd2,2'd0,1'b0,4'hC}  // R3 after soft reset
    };

    function automatic string tag_of(int i);
        case (i)
            0: return "R1";
            1: return "R2";
            2, 3, 11, 19: return "R3";
            14, 15: return "R4";
            4, 5, 8, 12, 16: return "R5";
            7, 17: return "R6";
            9, 10, 13: return "R7";
            6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [2:0] em, logic [1:0] es, logic el, logic [3:0] eb, logic ee);
        checks++;
        if (mode !== em || sel_idx !== es || lol_n !== el || bw_active !== eb || clk_out_en !== ee) begin
            fails++;
            $display("FAIL %s: mode/sel/lol_n/bw/en got %0d/%0d/%0b/%h/%0b expected %0d/%0d/%0b/%h/%0b",
                     req, mode, sel_idx, lol_n, bw_active, clk_out_en, em, es, el, eb, ee);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; soft_rst = 1'b0; init_done = 1'b0; in_valid = 4'b0110;
        auto_sel = 1'b1; man_sel = 2'd0; lock_ok = 1'b0; hist_valid = 1'b0;
        fastlock_en = 1'b1; bw_normal = 4'h3; bw_fast = 4'hC;
        repeat (3) tick();
        check("R1 reset state", 3'd0, 2'd0, 1'b0, 4'h3, 1'b0);
        rst_n = 1'b1;
        in_valid = 4'b0000;

        for (int i = 0; i < NV; i++) begin
            {soft_rst, init_done, in_valid, auto_sel, man_sel, lock_ok, hist_valid, fastlock_en} = VEC[i][21:10];
            tick();
            check(tag_of(i), VEC[i][9:7], VEC[i][6:5], VEC[i][4], VEC[i][3:0], VEC[i][9:7] != 3'd0);
        end

        // R5: lock on input 0 before the hard reset.
        soft_rst = 1'b0; init_done = 1'b0; lock_ok = 1'b1;
        tick();
        check("R5 lock before hard reset", 3'd3, 2'd0, 1'b1, 4'h3, 1'b1);

        // R1: hard reset from locked returns to init.
        rst_n = 1'b0;
        tick();
        check("R1 hard reset from locked", 3'd0, 2'd0, 1'b0, 4'h3, 1'b0);
        rst_n = 1'b1; auto_sel = 1'b1; in_valid = 4'b1100; lock_ok = 1'b0;
        repeat (4) tick();
        check("R1 init waits for strobe", 3'd0, 2'd0, 1'b0, 4'h3, 1'b0);

        // R10: soft reset has no effect in init.
        soft_rst = 1'b1;
        tick();
        check("R10 soft reset ignored in init", 3'd0, 2'd0, 1'b0, 4'h3, 1'b0);
        soft_rst = 1'b0;

        // R2: initialization completes.
        init_done = 1'b1;
        tick();
        check("R2 init to free-run", 3'd1, 2'd0, 1'b0, 4'h3, 1'b1);
        init_done = 1'b0;

        // R3: lowest of inputs 2 and 3 is chosen.
        tick();
        check("R3 lowest valid after re-init", 3'd2, 2'd2, 1'b0, 4'hC, 1'b1);

        // R8: bandwidth follows fastlock_en while acquiring.
        fastlock_en = 1'b0;
        #1;
        check("R8 fastlock disabled in acquisition", 3'd2, 2'd2, 1'b0, 4'h3, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule